// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block produces the bus-level timing of an I2C master. A byte engine asks it for one bus phase at a time: a start condition, one data bit, a repeated start, or a stop condition. The timer drives the SCL and SDA pull-down enables through that phase and then sends a one-cycle completion pulse. All phase lengths come from configuration words that the controller holds steady.

Each count is measured in prescaled ticks. One tick lasts `div+1` input clocks, where `div` is an 8-bit prescaler. A data bit has a low half and a high half. Each half also carries a fixed overhead of 4 clocks plus the input-filter depth, which models the synchroniser and glitch-filter latency in front of the SCL input. One bit therefore lasts (div+1)*(low+high+2) + 8 + 2*filter input clocks.

The accept edge is the rising clock edge at which `req_valid` is high while `busy` is low. All times below are counted in input clocks from that edge.

Top module: `i2c_scl_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `scl_low`, `sda_low`, `busy` and `done` are all 0.
- R2: Request kind 1 (data bit) holds SCL low, then releases it, then pulls it low again, and pulses `done` at that same time. The field positions are: filter depth at `cfg_word[18:16]`, `div` at `tim_c[23:16]`, low count at `tim_b[15:8]` and high count at `tim_b[7:0]`. When hold+setup does not exceed low+1, the bit lasts exactly (div+1)*(low+high+2)+8+2*filter clocks.
- R3: In a bit, SCL is released at L*(div+1)+4+filter clocks, and stays released for (high+1)*(div+1)+4+filter clocks. L is defined in R5.
- R4: In a bit, SDA takes its new value hold*(div+1) clocks after the accept edge, with hold at `tim_d[7:0]`. A bit value of 0 pulls SDA low and a value of 1 releases it.
- R5: The low half of a bit lasts L = max(low+1, hold+setup) ticks, with setup at `tim_b[31:24]`. This guarantees the data-setup time before SCL rises.
- R6: Request kind 0 (start) is issued from an idle bus. SDA is pulled low at (ssu+1)*(div+1) clocks. SCL is pulled low, and `done` pulses, at (ssu+shd+2)*(div+1) clocks. The fields are ssu at `tim_a[31:24]` and shd at `tim_a[23:16]`.
- R7: Request kind 2 (repeated start) releases SDA at the accept edge and releases SCL at (rel+1)*(div+1) clocks, with rel at `tim_c[7:0]`. It then runs the start sequence of R6 and pulses `done` at (rel+ssu+shd+3)*(div+1) clocks.
- R8: Request kind 3 (stop) pulls SDA low at the accept edge and releases SCL at (low+1)*(div+1) clocks. It releases SDA and pulses `done` at (low+psu+2)*(div+1) clocks, with psu at `tim_a[15:8]`. Both lines are then released.
- R9: `done` is high for exactly one cycle per accepted request. `busy` is low in that same cycle.
- R10: A request presented while `busy` is high is ignored: the running phase keeps its timing and its final line states.
- R11: While SCL is released during a data bit, SDA does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Configuration word; filter depth in [18:16] |
| tim_a | input | 32 | Start setup [31:24], start hold [23:16], stop setup [15:8] |
| tim_b | input | 32 | Data setup [31:24], SCL low [15:8], SCL high [7:0] |
| tim_c | input | 32 | Prescaler [23:16], repeated-start release [7:0] |
| tim_d | input | 32 | Data hold [7:0] |
| req_valid | input | 1 | Phase request strobe |
| req_kind | input | 2 | 0 start, 1 bit, 2 repeated start, 3 stop |
| req_bit | input | 1 | Bit value for kind 1 |
| scl_low | output | 1 | Drive SCL low when 1 |
| sda_low | output | 1 | Drive SDA low when 1 |
| busy | output | 1 | A phase is running |
| done | output | 1 | One-cycle phase completion pulse |

## Verification
Every output is registered, so an event due N clocks after the accept edge is visible just after rising edge N. The bench counts rising edges from the accept edge and samples at each falling edge. It records the first edge at which `scl_low` changes, the first edge at which `sda_low` changes, and the edge at which `done` appears. It compares these counts with the closed-form times given in R2 to R8, computed from the same field values. Sampling half a cycle away from the edges makes each comparison exact to one clock, and the check one edge after `done` confirms that the pulse does not stretch.

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer #(
  parameter int OVH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_word,
  input  logic [31:0] tim_a,
  input  logic [31:0] tim_b,
  input  logic [31:0] tim_c,
  input  logic [31:0] tim_d,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic        req_bit,
  output logic        scl_low,
  output logic        sda_low,
  output logic        busy,
  output logic        done
);
  localparam int FLD_W = 8;
  localparam int CNT_W = FLD_W + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_SSU, S_SHD, S_RLS, S_LOW, S_LOWX, S_HIGH, S_HIGHX, S_PLO, S_PSU
  } st_t;

  localparam logic [1:0] K_START  = 2'd0;
  localparam logic [1:0] K_BIT    = 2'd1;
  localparam logic [1:0] K_RSTART = 2'd2;
  localparam logic [1:0] K_STOP   = 2'd3;

  st_t              st;
  logic [FLD_W-1:0] pre;
  logic [CNT_W-1:0] tcnt;
  logic             bit_q;

  logic [FLD_W-1:0] ssu, shd, psu, dsu, tl, th, div, rel, dhd;
  logic [2:0]       flt;
  assign ssu = tim_a[31:24];
  assign shd = tim_a[23:16];
  assign psu = tim_a[15:8];
  assign dsu = tim_b[31:24];
  assign tl  = tim_b[15:8];
  assign th  = tim_b[7:0];
  assign div = tim_c[23:16];
  assign rel = tim_c[7:0];
  assign dhd = tim_d[7:0];
  assign flt = cfg_word[18:16];

  logic unused_fields;
  assign unused_fields = ^{cfg_word[31:19], cfg_word[15:0], tim_a[7:0],
                           tim_b[23:16], tim_c[31:24], tim_c[15:8], tim_d[31:8]};

  logic [CNT_W-1:0] lo_cnt, lo_data, lo_ticks, xlim, target, tnext;
  assign lo_cnt   = {1'b0, tl} + CNT_W'(1);
  assign lo_data  = {1'b0, dhd} + {1'b0, dsu};
  assign lo_ticks = (lo_data > lo_cnt) ? lo_data : lo_cnt;
  assign xlim     = CNT_W'(OVH) + CNT_W'(flt);
  assign tnext    = tcnt + CNT_W'(1);

  always_comb begin
    case (st)
      S_SSU:            target = {1'b0, ssu} + CNT_W'(1);
      S_SHD:            target = {1'b0, shd} + CNT_W'(1);
      S_RLS:            target = {1'b0, rel} + CNT_W'(1);
      S_LOW:            target = lo_ticks;
      S_HIGH:           target = {1'b0, th} + CNT_W'(1);
      S_LOWX, S_HIGHX:  target = xlim;
      S_PLO:            target = lo_cnt;
      S_PSU:            target = {1'b0, psu} + CNT_W'(1);
      default:          target = CNT_W'(1);
    endcase
  end

  logic xphase, tick, step, phase_end, hold_hit, scl_high_bit;
  assign busy         = (st != S_IDLE);
  assign xphase       = (st == S_LOWX) || (st == S_HIGHX);
  assign tick         = (pre == div);
  assign step         = xphase || tick;
  assign phase_end    = busy && step && (tnext == target);
  assign hold_hit     = (st == S_LOW) && tick && (tnext == {1'b0, dhd});
  assign scl_high_bit = (st == S_HIGH) || (st == S_HIGHX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pre     <= '0;
      tcnt    <= '0;
      bit_q   <= 1'b0;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          bit_q <= req_bit;
          pre   <= '0;
          tcnt  <= '0;
          case (req_kind)
            K_START:  st <= S_SSU;
            K_BIT: begin
              st <= S_LOW;
              if (dhd == '0) sda_low <= !req_bit;
            end
            K_RSTART: begin
              st      <= S_RLS;
              sda_low <= 1'b0;
            end
            K_STOP: begin
              st      <= S_PLO;
              sda_low <= 1'b1;
            end
            default: st <= S_IDLE;
          endcase
        end
      end else begin
        if (hold_hit) sda_low <= !bit_q;
        if (phase_end) begin
          pre  <= '0;
          tcnt <= '0;
          case (st)
            S_SSU: begin
              sda_low <= 1'b1;
              st      <= S_SHD;
            end
            S_SHD: begin
              scl_low <= 1'b1;
              done    <= 1'b1;
              st      <= S_IDLE;
            end
            S_RLS: begin
              scl_low <= 1'b0;
              st      <= S_SSU;
            end
            S_LOW:  st <= S_LOWX;
            S_LOWX: begin
              scl_low <= 1'b0;
              st      <= S_HIGH;
            end
            S_HIGH: st <= S_HIGHX;
            S_HIGHX: begin
              scl_low <= 1'b1;
              done    <= 1'b1;
              st      <= S_IDLE;
            end
            S_PLO: begin
              scl_low <= 1'b0;
              st      <= S_PSU;
            end
            S_PSU: begin
              sda_low <= 1'b0;
              done    <= 1'b1;
              st      <= S_IDLE;
            end
            default: st <= S_IDLE;
          endcase
        end else begin
          if (step) tcnt <= tnext;
          if (!xphase) pre <= tick ? '0 : pre + FLD_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic scl_low,
  input logic sda_low,
  input logic scl_high_bit
);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  p_scl_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_high_bit |-> !scl_low);

  p_sda_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    scl_high_bit |-> $stable(sda_low));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !scl_low) |-> !sda_low);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .busy(busy),
  .done(done),
  .scl_low(scl_low),
  .sda_low(sda_low),
  .scl_high_bit(scl_high_bit)
);

// File: tb/sim_i2c_scl_timer.sv
module sim_i2c_scl_timer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [31:0] cfg_word, tim_a, tim_b, tim_c, tim_d;
  logic        req_valid, req_bit;
  logic [1:0]  req_kind;
  logic        scl_low, sda_low, busy, done;

  int checks = 0;
  int fails  = 0;

  i2c_scl_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .tim_a(tim_a), .tim_b(tim_b),
    .tim_c(tim_c), .tim_d(tim_d), .req_valid(req_valid), .req_kind(req_kind),
    .req_bit(req_bit), .scl_low(scl_low), .sda_low(sda_low), .busy(busy), .done(done)
  );

  // fields: kind bit div low high hold setup filter ssu shd psu rel
  localparam bit [95:0] VEC [0:7] = '{
    96'h00_00_01_00_00_00_00_00_03_02_00_00,
    96'h01_00_02_05_04_02_02_03_00_00_00_00,
    96'h01_01_00_03_02_01_05_00_00_00_00_00,
    96'h01_00_03_07_07_00_01_07_00_00_00_00,
    96'h02_00_01_00_00_00_00_00_01_01_00_02,
    96'h01_01_01_04_03_02_01_02_00_00_00_00,
    96'h03_00_02_03_00_00_00_00_00_00_02_00,
    96'h00_00_00_00_00_00_00_00_00_00_00_00
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input bit [95:0] v);
    cfg_word = {13'd0, v[34:32], 16'd0};
    tim_a    = {v[31:24], v[23:16], v[15:8], 8'd0};
    tim_b    = {v[47:40], 8'd0, v[71:64], v[63:56]};
    tim_c    = {8'd0, v[79:72], 8'd0, v[7:0]};
    tim_d    = {24'd0, v[55:48]};
  endtask

  function automatic void expect_vals(input bit [95:0] v, input logic psda,
                                      output int ed, output int es, output int esd);
    int k, b, d, tl, th, hold, dsu, flt, ssu, shd, psu, rel, x, l;
    k = v[95:88]; b = v[80]; d = v[79:72] + 1; tl = v[71:64]; th = v[63:56];
    hold = v[55:48]; dsu = v[47:40]; flt = v[39:32]; ssu = v[31:24];
    shd = v[23:16]; psu = v[15:8]; rel = v[7:0];
    x = 4 + flt;
    l = (hold + dsu > tl + 1) ? hold + dsu : tl + 1;
    case (k)
      0: begin esd = (ssu + 1) * d; es = (ssu + shd + 2) * d; ed = es; end
      1: begin
        es  = l * d + x;
        ed  = es + (th + 1) * d + x;
        esd = (psda != !b[0]) ? hold * d : -1;
      end
      2: begin
        es  = (rel + 1) * d;
        ed  = (rel + ssu + shd + 3) * d;
        esd = psda ? 0 : (rel + ssu + 2) * d;
      end
      default: begin
        es  = (tl + 1) * d;
        ed  = (tl + psu + 2) * d;
        esd = psda ? ed : 0;
      end
    endcase
  endfunction

  task automatic run(input logic [1:0] k, input logic b, input int inj,
                     output int td, output int ts, output int tsd,
                     output logic psda, output int viol);
    logic pscl, lscl, lsda;
    int n;
    @(negedge clk);
    req_kind = k; req_bit = b; req_valid = 1'b1;
    pscl = scl_low; psda = sda_low; lscl = pscl; lsda = psda;
    td = -1; ts = -1; tsd = -1; viol = 0; n = 0;
    @(posedge clk);
    while (n < 3000) begin
      @(negedge clk);
      if (n == inj) begin req_valid = 1'b1; req_kind = 2'd3; end
      else req_valid = 1'b0;
      if (ts < 0 && scl_low != pscl) ts = n;
      if (tsd < 0 && sda_low != psda) tsd = n;
      if (k == 2'd1 && !scl_low && !lscl && sda_low != lsda) viol++;
      lscl = scl_low; lsda = sda_low;
      if (done) begin td = n; break; end
      @(posedge clk);
      n++;
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int td, ts, tsd, viol, ed, es, esd;
    logic psda;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_bit = 1'b0;
    load('0);
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {scl_low, sda_low, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {scl_low, sda_low, busy, done}, 0);

    for (int i = 0; i < 8; i++) begin
      load(VEC[i]);
      run(VEC[i][89:88], VEC[i][80], -1, td, ts, tsd, psda, viol);
      expect_vals(VEC[i], psda, ed, es, esd);
      case (VEC[i][89:88])
        2'd0: begin
          chk("R6 start done", td, ed); chk("R6 start scl", ts, es); chk("R6 start sda", tsd, esd);
        end
        2'd1: begin
          chk("R2 bit done", td, ed);
          if (VEC[i][55:48] + VEC[i][47:40] > VEC[i][71:64] + 1) chk("R5 stretched scl release", ts, es);
          else chk("R3 bit scl release", ts, es);
          chk("R4 bit sda change", tsd, esd);
          chk("R11 sda still while scl high", viol, 0);
        end
        2'd2: begin
          chk("R7 rstart done", td, ed); chk("R7 rstart scl", ts, es); chk("R7 rstart sda", tsd, esd);
        end
        default: begin
          chk("R8 stop done", td, ed); chk("R8 stop scl", ts, es); chk("R8 stop sda", tsd, esd);
        end
      endcase
    end

    // R10: stop request injected mid-bit is ignored
    load(96'h01_01_01_04_03_01_01_00_00_00_00_00);
    run(2'd1, 1'b1, 5, td, ts, tsd, psda, viol);
    chk("R10 done unchanged", td, 26);
    chk("R10 scl release unchanged", ts, 14);
    chk("R10 scl low after bit", scl_low, 1);
    chk("R10 sda released after bit", sda_low, 0);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R10 no stop started", busy, 0);

    // R8: final stop leaves both lines released
    load(96'h03_00_00_01_00_00_00_00_00_00_01_00);
    run(2'd3, 1'b0, -1, td, ts, tsd, psda, viol);
    chk("R8 stop done short", td, 4);
    chk("R8 stop scl short", ts, 2);
    chk("R8 lines released", {scl_low, sda_low}, 0);
    chk("R9 busy low with done", busy, 0);

    // R1: reset in the middle of a start
    load(96'h00_00_03_00_00_00_00_00_05_05_00_00);
    @(negedge clk); req_kind = 2'd0; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-phase reset", {scl_low, sda_low, busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule